// File: doc/BRIEF.md
# Multi-Field Binary Polynomial Reducer

This block turns a carry-less product of two binary field elements into a proper element of the field. A multiplier ahead of it delivers a 15-bit product whose bit positions are the polynomial coefficients. A small selector says which field is in use: degree 6, 7 or 8. The block folds every product bit of degree m or above back onto the low word. It does this with a precomputed image of that power of the generator, taken modulo the field polynomial, and it emits the reduced element on an 8-bit word.

The field polynomials are x^6+x+1, x^7+x^3+1 and x^8+x^4+x^3+x^2+1. The table of reduced powers is worked out at elaboration time from these polynomials. For each product position, the table row is gated by that product bit, and all gated rows are XOR-accumulated onto the low m product bits in a single flat stage. A register with a clock enable holds the reduced word, and it loads only when the input is marked valid.

Top module: `gfr_reducer`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock cycle. The reduced word for an input accepted at a rising edge is on `result` right after that edge.
- R2: With `field_sel` = 6, `result` equals `prod` modulo x^6+x+1, for every product of two 6-bit operands.
- R3: With `field_sel` = 7, `result` equals `prod` modulo x^7+x^3+1, for every product of two 7-bit operands.
- R4: With `field_sel` = 8, `result` equals `prod` modulo x^8+x^4+x^3+x^2+1, for every product of two 8-bit operands.
- R5: Product bits above position 2m-2 have no effect on `result`.
- R6: A `field_sel` value other than 6, 7 or 8 gives `result` = 0.
- R7: While `rst_n` is low, `out_valid` and `result` are 0.
- R8: A cycle with `in_valid` low leaves `result` unchanged and drives `out_valid` low, whatever `prod` and `field_sel` carry.
- R9: For m < 8, the bits of `result` at positions m to 7 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Product and selector are valid this cycle |
| field_sel | input | 4 | Field degree m as an unsigned binary number (6, 7 or 8) |
| prod | input | 15 | Carry-less product, bit i is the coefficient of x^i |
| out_valid | output | 1 | `result` holds a newly reduced element |
| result | output | 8 | Reduced field element, low m bits significant |

## Verification
There is exactly one register between the ports, so every reduced word appears one rising edge after its input is accepted. The driver pushes its expected word into the queue at the same falling edge where it applies the input. The monitor pops and compares on the first falling edge at which `out_valid` is high, which comes one cycle later. Idle-cycle hold checks and reset checks are also sampled on falling edges, after the edge on which the register would have changed. The expected words come from a bench-side carry-less multiply followed by bitwise long division over every operand pair of each field.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

  // Full field polynomial (including the x^m term) for a supported degree.
  function automatic logic [15:0] field_poly(int unsigned m);
    case (m)
      6:       return 16'h0043;  // x^6 + x + 1
      7:       return 16'h0089;  // x^7 + x^3 + 1
      8:       return 16'h011D;  // x^8 + x^4 + x^3 + x^2 + 1
      default: return 16'h0000;
    endcase
  endfunction

  // Canonical representation of alpha^k in the degree-m field.
  function automatic logic [15:0] alpha_power(int unsigned m, int unsigned k);
    logic [15:0] acc;
    acc = 16'h0001;
    for (int s = 0; s < 32; s++) begin
      if (s < int'(k)) begin
        acc = acc << 1;
        if (acc[m]) acc = acc ^ field_poly(m);
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/gfr_power_rom.sv
module gfr_power_rom #(
  parameter int MIN_M  = 6,
  parameter int MAX_M  = 8,
  parameter int PROD_W = 2 * MAX_M - 1,
  parameter int WORD_W = MAX_M,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]              field_sel,
  output logic [PROD_W-1:0][WORD_W-1:0] pow_row,
  output logic                          sel_ok
);
  import gfr_pkg::*;

  localparam int NUM_F = MAX_M - MIN_M + 1;

  logic [PROD_W-1:0][NUM_F-1:0][WORD_W-1:0] cand;

  // Constant table: row k holds alpha^k for each field whose fold range
  // covers position k, zero otherwise.
  for (genvar k = 0; k < PROD_W; k++) begin : g_pos
    for (genvar f = 0; f < NUM_F; f++) begin : g_fld
      localparam int FM = MIN_M + f;
      localparam logic [15:0] PW = alpha_power(FM, k);
      localparam logic [WORD_W-1:0] ENTRY =
        ((k >= FM) && (k <= 2 * FM - 2)) ? PW[WORD_W-1:0] : '0;
      assign cand[k][f] = ENTRY;
    end
  end

  always_comb begin
    sel_ok  = (int'(field_sel) >= MIN_M) && (int'(field_sel) <= MAX_M);
    pow_row = '0;
    for (int f = 0; f < NUM_F; f++) begin
      if (int'(field_sel) == MIN_M + f) begin
        for (int k = 0; k < PROD_W; k++) pow_row[k] = cand[k][f];
      end
    end
  end

endmodule

// File: rtl/gfr_low_route.sv
module gfr_low_route #(
  parameter int MIN_M  = 6,
  parameter int MAX_M  = 8,
  parameter int PROD_W = 2 * MAX_M - 1,
  parameter int WORD_W = MAX_M,
  parameter int SEL_W  = 4
) (
  input  logic [PROD_W-1:0] prod,
  input  logic [SEL_W-1:0]  field_sel,
  output logic [WORD_W-1:0] low_word
);
  // Bits below the smallest degree always belong to the low word.
  assign low_word[MIN_M-1:0] = prod[MIN_M-1:0];

  // Bits between MIN_M and MAX_M-1 join the low word only when the
  // selected degree exceeds their position; otherwise they are folded.
  for (genvar j = MIN_M; j < WORD_W; j++) begin : g_route
    assign low_word[j] = prod[j] & (int'(field_sel) > j);
  end

endmodule

// File: rtl/gfr_fold.sv
module gfr_fold #(
  parameter int PROD_W = 15,
  parameter int WORD_W = 8
) (
  input  logic [PROD_W-1:0]             prod,
  input  logic [PROD_W-1:0][WORD_W-1:0] pow_row,
  input  logic [WORD_W-1:0]             low_word,
  output logic [WORD_W-1:0]             folded
);
  logic [PROD_W-1:0][WORD_W-1:0] gated;

  // AND level: each table row is enabled by its product bit.
  for (genvar k = 0; k < PROD_W; k++) begin : g_gate
    assign gated[k] = pow_row[k] & {WORD_W{prod[k]}};
  end

  // XOR accumulation onto the low word.
  always_comb begin
    folded = low_word;
    for (int k = 0; k < PROD_W; k++) folded = folded ^ gated[k];
  end

endmodule

// File: rtl/gfr_reducer.sv
module gfr_reducer #(
  parameter int MIN_M = 6,
  parameter int MAX_M = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [3:0]             field_sel,
  input  logic [2*MAX_M-2:0]     prod,
  output logic                   out_valid,
  output logic [MAX_M-1:0]       result
);
  localparam int PROD_W = 2 * MAX_M - 1;
  localparam int WORD_W = MAX_M;
  localparam int SEL_W  = 4;

  logic [PROD_W-1:0][WORD_W-1:0] pow_row;
  logic                          sel_ok;
  logic [WORD_W-1:0]             low_word;
  logic [WORD_W-1:0]             folded;
  logic [WORD_W-1:0]             result_d;
  logic                          result_en;
  logic                          valid_d;

  gfr_power_rom #(
    .MIN_M(MIN_M), .MAX_M(MAX_M), .PROD_W(PROD_W),
    .WORD_W(WORD_W), .SEL_W(SEL_W)
  ) u_rom (
    .field_sel (field_sel),
    .pow_row   (pow_row),
    .sel_ok    (sel_ok)
  );

  gfr_low_route #(
    .MIN_M(MIN_M), .MAX_M(MAX_M), .PROD_W(PROD_W),
    .WORD_W(WORD_W), .SEL_W(SEL_W)
  ) u_route (
    .prod      (prod),
    .field_sel (field_sel),
    .low_word  (low_word)
  );

  gfr_fold #(
    .PROD_W(PROD_W), .WORD_W(WORD_W)
  ) u_fold (
    .prod      (prod),
    .pow_row   (pow_row),
    .low_word  (low_word),
    .folded    (folded)
  );

  // Next-state logic.
  always_comb begin
    result_en = in_valid;
    result_d  = sel_ok ? folded : '0;
    valid_d   = in_valid;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= valid_d;
      if (result_en) result <= result_d;
    end
  end

  // R1: valid follows input valid by one cycle.
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6: unsupported selector yields zero.
  assert_bad_sel_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(field_sel >= 4'(MIN_M) && field_sel <= 4'(MAX_M)))
      |=> (result == '0));

  // R8: idle cycles hold the result.
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R9: upper bits zero for the smaller fields.
  assert_upper_zero6_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && field_sel == 4'd6) |=> (result[WORD_W-1:6] == '0));
  assert_upper_zero7_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && field_sel == 4'd7) |=> (result[WORD_W-1:7] == '0));

endmodule

// File: tb/gfr_reducer_tb.sv
`timescale 1ns/1ps
module gfr_reducer_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  field_sel;
  logic [14:0] prod;
  logic        out_valid;
  logic [7:0]  result;

  int checks;
  int errors;
  bit done;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  gfr_reducer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .field_sel (field_sel),
    .prod      (prod),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [14:0] ref_clmul(logic [7:0] a, logic [7:0] b);
    logic [14:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (15'(a) << i);
    return acc;
  endfunction

  function automatic logic [7:0] ref_reduce(logic [14:0] p, int m);
    logic [15:0] w;
    logic [15:0] poly;
    case (m)
      6: poly = 16'h0043;
      7: poly = 16'h0089;
      8: poly = 16'h011D;
      default: return 8'h00;
    endcase
    w = {1'b0, p} & ((16'h1 << (2 * m - 1)) - 16'h1);
    for (int i = 14; i >= 0; i--)
      if (i >= m && w[i]) w = w ^ (poly << (i - m));
    return w[7:0];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic drive(logic [3:0] sel, logic [14:0] p, string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    field_sel = sel;
    prod      = p;
    exp_q.push_back(ref_reduce(p, int'(sel)));
    tag_q.push_back(tag);
  endtask

  // Monitor: pops the scoreboard when the design presents a result.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1 actual=out_valid expected=no output");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, result, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 actual=watchdog expired expected=run complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    field_sel = 4'd8;
    prod = 15'h7FFF;

    // R7: reset state, inputs active.
    in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R7 out_valid", {7'd0, out_valid}, 8'h00);
      check("R7 result", result, 8'h00);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2, R3, R4: every operand pair for each field.
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        drive(4'd6, ref_clmul(8'(a), 8'(b)), "R2 m6");
    for (int a = 0; a < 128; a++)
      for (int b = 0; b < 128; b++)
        drive(4'd7, ref_clmul(8'(a), 8'(b)), "R3 m7");
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive(4'd8, ref_clmul(8'(a), 8'(b)), "R4 m8");

    // R5 / R9: garbage above 2m-2 ignored, upper result bits zero.
    for (int n = 0; n < 64; n++) begin
      logic [14:0] base;
      base = ref_clmul(8'(n * 5 + 3) & 8'h3F, 8'(n * 11 + 1) & 8'h3F);
      drive(4'd6, base | (15'(n + 1) << 11), "R5 R9 m6 high bits");
      base = ref_clmul(8'(n * 7 + 2) & 8'h7F, 8'(n * 13 + 9) & 8'h7F);
      drive(4'd7, base | (15'((n % 3) + 1) << 13), "R5 R9 m7 high bits");
    end

    // R6: unsupported selector values.
    for (int s = 0; s < 16; s++)
      if (s < 6 || s > 8) drive(4'(s), 15'h7FFF - 15'(s * 97), "R6 bad sel");

    // R1: back-to-back then gaps.
    drive(4'd8, 15'h4001, "R1 burst");
    @(negedge clk);
    in_valid = 1'b0;
    drive(4'd8, 15'h2A55, "R1 after gap");
    @(negedge clk);
    in_valid = 1'b0;

    // Drain.
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 actual=%0d pending expected=0", exp_q.size());
    end

    // R8: idle cycles with changing inputs.
    last = ref_reduce(15'h2A55, 8);
    for (int n = 0; n < 6; n++) begin
      field_sel = 4'(6 + (n % 3));
      prod = 15'(n * 4099 + 77);
      @(negedge clk);
      check("R8 hold", result, last);
      check("R8 out_valid", {7'd0, out_valid}, 8'h00);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule